// File: doc/BRIEF.md
# Accumulator-Routed Eight-Bit Processor Core

This block is a small 8-bit processor. It fetches 14-bit instruction words from a 64-entry program store and executes one of eight operations. Every data transfer passes through a single working register, W. No operation copies one register directly into another. The only conditional branch tests whether W is zero. Each instruction takes three clocks: fetch, decode and execute.

Eight register slots can be addressed by index. Slots 0 to 3 are plain storage. Slots 4 to 7 belong to an arithmetic unit mapped into the register space: two operand registers, a result register and a flag register. An ALU instruction combines the two operands under an 8-bit control literal and writes the result and the flags. The only output is a print instruction, which places W on an 8-bit bus and pulses a strobe.

Code is placed in the program store through a write port. That port may be written while the core is held in reset or while it is running. After reset is released, the core starts execution at address 0.

Top module: `accum_core`

## Requirements
- R1: Synchronous reset clears the program counter, W, general registers 0-3 and the four arithmetic registers to zero. The print strobe is low during reset and in the clock that follows it.
- R2: Every instruction takes exactly three clocks. The instruction fetched k-th after reset release (k from 0) is in its execute step in clock 3k+2, counting the first edge after release as edge 1. The print strobe is high for exactly one clock, during the execute step of a print instruction. The program counter changes only at the end of an execute step.
- R3: Instruction word layout: bits [13:11] opcode, [10:8] register index, [7:0] literal. Opcodes: 000 no-op, 001 load the literal into the indexed register, 010 copy the indexed register into W, 011 copy W into the indexed register, 100 print W, 101 ALU operation with the literal as control, 110 jump, 111 jump if W is zero.
- R4: Indices 0-3 select four independent 8-bit registers. Loading or moving into one of them leaves the other three unchanged.
- R5: Indices 4, 5, 6 and 7 select ALU operand A, operand B, result and flags. All four can be read and written by load and move instructions. An ALU operation leaves A and B unchanged.
- R6: ALU control bits: bit0 forces A to zero, bit1 inverts A after that, bit2 forces B to zero, bit3 inverts B after that, bit4 selects sum modulo 256 (else bitwise AND), bit5 inverts the result. Bits 7:6 have no effect.
- R7: After an ALU operation, flags bit0 is 1 exactly when the result is zero, bit1 equals result bit 7, and bits 7:2 are zero.
- R8: A no-op changes neither W nor any register.
- R9: A jump loads the program counter with literal bits [5:0]; bits [7:6] are dropped.
- R10: A jump-if-zero is taken, like R9, exactly when W is zero; otherwise execution continues at the next address.
- R11: The program counter advances by one modulo 64, so address 63 is followed by address 0.
- R12: A word written through the load port is executed by any later fetch of that address. A fetch in the same clock as a write to the same address returns the previous word.
- R13: During the print strobe the output bus equals W, and printing leaves W unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Program store write enable |
| progAddr | input | 6 | Program store write address |
| progData | input | 14 | Instruction word to write |
| outData | output | 8 | Printed value (W) |
| outStrobe | output | 1 | One-clock print pulse |

## Verification
The program store's write port and the core's own instruction fetch can land on the same word in the same clock. The bench provokes this by releasing reset in the same cycle that it rewrites address 0. The fetch at address 0 therefore coincides with the write. The program prints a register loaded from address 0 and then loops back, so the old literal must appear on the first pass and the new one on the second, each at the cycle predicted by the three-clock cadence.

// File: rtl/accum_core_pkg.sv
package accum_core_pkg;

  localparam int DATA_W   = 8;
  localparam int IDX_W    = 3;
  localparam int OP_W     = 3;
  localparam int INSTR_W  = OP_W + IDX_W + DATA_W;
  localparam int NUM_GPR  = 4;
  localparam int GPR_SEL_W = $clog2(NUM_GPR);
  localparam int ALU_CTRL_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'b000,
    OP_LIT = 3'b001,
    OP_RDW = 3'b010,
    OP_WRR = 3'b011,
    OP_PRT = 3'b100,
    OP_ALU = 3'b101,
    OP_JMP = 3'b110,
    OP_JZ  = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  // Strobes handed from control to datapath, valid only in the execute step.
  typedef struct packed {
    logic              valid;
    logic              litToReg;
    logic              regToW;
    logic              wToReg;
    logic              print;
    logic              aluRun;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] lit;
  } dp_stb_t;

endpackage

// File: rtl/accum_progmem.sv
module accum_progmem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  // Read returns the word held before a same-cycle write.
  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrWord;
    if (rdEn) rdWord <= store[rdAddr];
  end

endmodule

// File: rtl/accum_control.sv
module accum_control
  import accum_core_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               wIsZero,
  output logic               fetchEn,
  output logic [ADDR_W-1:0]  pc,
  output dp_stb_t            dpStb
);
  phase_e            phase;
  logic [ADDR_W-1:0] pcQ;
  dp_stb_t           stbQ;
  dp_stb_t           stbDec;
  logic              jmpQ;
  logic              jzQ;
  logic              jmpDec;
  logic              jzDec;
  logic              taken;
  logic [ADDR_W-1:0] pcNext;
  opcode_e           op;

  assign op = opcode_e'(instrWord[INSTR_W-1 -: OP_W]);

  always_comb begin
    stbDec       = '0;
    stbDec.valid = 1'b1;
    stbDec.idx   = instrWord[DATA_W +: IDX_W];
    stbDec.lit   = instrWord[DATA_W-1:0];
    jmpDec       = 1'b0;
    jzDec        = 1'b0;
    case (op)
      OP_LIT:  stbDec.litToReg = 1'b1;
      OP_RDW:  stbDec.regToW   = 1'b1;
      OP_WRR:  stbDec.wToReg   = 1'b1;
      OP_PRT:  stbDec.print    = 1'b1;
      OP_ALU:  stbDec.aluRun   = 1'b1;
      OP_JMP:  jmpDec          = 1'b1;
      OP_JZ:   jzDec           = 1'b1;
      default: ;
    endcase
  end

  assign taken  = jmpQ | (jzQ & wIsZero);
  assign pcNext = taken ? stbQ.lit[ADDR_W-1:0] : pcQ + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pcQ   <= '0;
      stbQ  <= '0;
      jmpQ  <= 1'b0;
      jzQ   <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: phase <= PH_DECODE;
        PH_DECODE: begin
          stbQ  <= stbDec;
          jmpQ  <= jmpDec;
          jzQ   <= jzDec;
          phase <= PH_EXEC;
        end
        default: begin
          stbQ  <= '0;
          jmpQ  <= 1'b0;
          jzQ   <= 1'b0;
          pcQ   <= pcNext;
          phase <= PH_FETCH;
        end
      endcase
    end
  end

  assign fetchEn = (phase == PH_FETCH);
  assign pc      = pcQ;
  assign dpStb   = stbQ;

endmodule

// File: rtl/accum_alu_regs.sv
module accum_alu_regs
  import accum_core_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  run,
  input  logic [ALU_CTRL_W-1:0] ctrl,
  input  logic [1:0]            rdSel,
  output logic [DATA_W-1:0]     rdData
);
  localparam int SLOTS = 4;

  logic [DATA_W-1:0] slotQ [SLOTS];
  logic [DATA_W-1:0] xPre, xOp, yPre, yOp, core, result, flagsNew;

  // Operand conditioning, combine, and optional inversion of the result.
  always_comb begin
    xPre   = ctrl[0] ? '0 : slotQ[0];
    xOp    = ctrl[1] ? ~xPre : xPre;
    yPre   = ctrl[2] ? '0 : slotQ[1];
    yOp    = ctrl[3] ? ~yPre : yPre;
    core   = ctrl[4] ? (xOp + yOp) : (xOp & yOp);
    result = ctrl[5] ? ~core : core;
    flagsNew    = '0;
    flagsNew[0] = (result == '0);
    flagsNew[1] = result[DATA_W-1];
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slotQ[s] <= '0;
      end else if (wrEn && (wrSel == 2'(s))) begin
        slotQ[s] <= wrData;
      end else if (run && s == 2) begin
        slotQ[s] <= result;
      end else if (run && s == 3) begin
        slotQ[s] <= flagsNew;
      end
    end
  end

  assign rdData = slotQ[rdSel];

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dp_stb_t           stb,
  output logic              wIsZero,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe
);
  logic [DATA_W-1:0] wQ;
  logic [DATA_W-1:0] gprQ [NUM_GPR];
  logic [DATA_W-1:0] aluRd;
  logic [DATA_W-1:0] rdVal;
  logic [DATA_W-1:0] wrVal;
  logic              regWr;
  logic              toAlu;

  assign toAlu = stb.idx[IDX_W-1];
  assign regWr = stb.valid & (stb.litToReg | stb.wToReg);
  assign wrVal = stb.litToReg ? stb.lit : wQ;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst) begin
        gprQ[g] <= '0;
      end else if (regWr && !toAlu && stb.idx[GPR_SEL_W-1:0] == GPR_SEL_W'(g)) begin
        gprQ[g] <= wrVal;
      end
    end
  end

  accum_alu_regs u_alu (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (regWr & toAlu),
    .wrSel  (stb.idx[1:0]),
    .wrData (wrVal),
    .run    (stb.valid & stb.aluRun),
    .ctrl   (stb.lit[ALU_CTRL_W-1:0]),
    .rdSel  (stb.idx[1:0]),
    .rdData (aluRd)
  );

  assign rdVal = toAlu ? aluRd : gprQ[stb.idx[GPR_SEL_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wQ <= '0;
    end else if (stb.valid && stb.regToW) begin
      wQ <= rdVal;
    end
  end

  assign wIsZero   = (wQ == '0);
  assign outData   = wQ;
  assign outStrobe = stb.valid & stb.print;

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_core_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progWe,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [INSTR_W-1:0] progData,
  output logic [DATA_W-1:0]  outData,
  output logic               outStrobe
);
  logic [INSTR_W-1:0] instrWord;
  logic [ADDR_W-1:0]  pcVal;
  logic               fetchEn;
  logic               wZero;
  dp_stb_t            dpStb;

  accum_progmem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) u_mem (
    .clk    (clk),
    .wrEn   (progWe),
    .wrAddr (progAddr),
    .wrWord (progData),
    .rdEn   (fetchEn),
    .rdAddr (pcVal),
    .rdWord (instrWord)
  );

  accum_control #(.ADDR_W(ADDR_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .instrWord (instrWord),
    .wIsZero   (wZero),
    .fetchEn   (fetchEn),
    .pc        (pcVal),
    .dpStb     (dpStb)
  );

  accum_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (dpStb),
    .wIsZero   (wZero),
    .outData   (outData),
    .outStrobe (outStrobe)
  );

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk
  import accum_core_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               outStrobe,
  input logic [DATA_W-1:0]  outData,
  input logic [ADDR_W-1:0]  pc,
  input logic [INSTR_W-1:0] instrWord,
  input logic               wIsZero,
  input dp_stb_t            stb
);
  logic [OP_W-1:0] opNow;
  assign opNow = instrWord[INSTR_W-1 -: OP_W];

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !outStrobe);

  a_r2_print_one_clock: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> !outStrobe);

  a_r2_print_spacing: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> ##1 !outStrobe);

  a_r2_pc_holds_outside_exec: assert property (@(posedge clk) disable iff (rst)
    !stb.valid |=> $stable(pc));

  a_r13_print_keeps_w: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> $stable(outData));

  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && opNow == 3'b110) |=> pc == $past(instrWord[ADDR_W-1:0]));

  a_r10_jz_taken: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && opNow == 3'b111 && wIsZero) |=> pc == $past(instrWord[ADDR_W-1:0]));

  a_r10_jz_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && opNow == 3'b111 && !wIsZero) |=> pc == ADDR_W'($past(pc) + 1'b1));

  a_r11_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && opNow[2:1] != 2'b11) |=> pc == ADDR_W'($past(pc) + 1'b1));

endmodule

bind accum_core accum_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .outStrobe (outStrobe),
  .outData   (outData),
  .pc        (pcVal),
  .instrWord (instrWord),
  .wIsZero   (wZero),
  .stb       (dpStb)
);

// File: tb/accum_core_bench.sv
module accum_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [2:0] NOP = 3'b000, LIT = 3'b001, RDW = 3'b010, WRR = 3'b011,
                         PRT = 3'b100, ALU = 3'b101, JMP = 3'b110, JZ = 3'b111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progWe = 1'b0;
  logic [5:0]  progAddr = '0;
  logic [13:0] progData = '0;
  wire  [7:0]  outData;
  wire         outStrobe;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_core u_accum_core (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .outData(outData), .outStrobe(outStrobe)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wallCyc = 0;
  logic [13:0] prog [64];
  logic [7:0]  outs [16];
  int          stamps [16];
  int          nOut;
  bit          dblStb;
  bit          prevStb;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      nOut = 0;
      dblStb = 0;
    end else if (outStrobe) begin
      if (nOut < 16) begin
        outs[nOut] = outData;
        stamps[nOut] = cyc;
      end
      nOut++;
      if (prevStb) dblStb = 1;
    end
    prevStb = !rst && outStrobe;
  end

  always @(posedge clk) begin
    wallCyc++;
    if (wallCyc > WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", wallCyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [13:0] enc(input logic [2:0] op, input logic [2:0] r, input logic [7:0] d);
    return {op, r, d};
  endfunction

  function automatic logic [7:0] aluRef(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] x, y, r;
    x = c[0] ? 8'h00 : a;
    if (c[1]) x = ~x;
    y = c[2] ? 8'h00 : b;
    if (c[3]) y = ~y;
    r = c[4] ? 8'(x + y) : (x & y);
    if (c[5]) r = ~r;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runProg(input int nWords, input int cycles, input bit race, input logic [13:0] raceWord);
    @(negedge clk);
    rst = 1'b1;
    for (int a = 0; a < nWords; a++) begin
      @(negedge clk);
      progWe = 1'b1;
      progAddr = 6'(a);
      progData = prog[a];
    end
    @(negedge clk);
    progWe = 1'b0;
    @(negedge clk);
    check("R1 reset quiet, W zero", {23'd0, outStrobe, outData}, 32'd0);
    rst = 1'b0;
    if (race) begin
      progWe = 1'b1;
      progAddr = 6'd0;
      progData = raceWord;
    end
    @(negedge clk);
    progWe = 1'b0;
    repeat (cycles - 1) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 64; a++) prog[a] = enc(NOP, 3'd0, 8'h00);

    // R3 R4 R8 R13: literal loads, moves through W, no-op, repeated print
    prog[0]  = enc(LIT, 3'd0, 8'hA1);
    prog[1]  = enc(LIT, 3'd1, 8'h5B);
    prog[2]  = enc(LIT, 3'd2, 8'hFF);
    prog[3]  = enc(LIT, 3'd3, 8'h3C);
    prog[4]  = enc(RDW, 3'd2, 8'h00);
    prog[5]  = enc(PRT, 3'd0, 8'h00);
    prog[6]  = enc(RDW, 3'd0, 8'h00);
    prog[7]  = enc(WRR, 3'd1, 8'h00);
    prog[8]  = enc(RDW, 3'd1, 8'h00);
    prog[9]  = enc(PRT, 3'd0, 8'h00);
    prog[10] = enc(RDW, 3'd3, 8'h00);
    prog[11] = enc(PRT, 3'd0, 8'h00);
    prog[12] = enc(NOP, 3'd2, 8'h77);
    prog[13] = enc(PRT, 3'd0, 8'h00);
    prog[14] = enc(JMP, 3'd0, 8'd14);
    runProg(15, 60, 1'b0, '0);
    check("R3 print count", nOut, 4);
    check("R3 load and move r2", outs[0], 8'hFF);
    check("R4 W to r1 copies r0", outs[1], 8'hA1);
    check("R4 r3 independent", outs[2], 8'h3C);
    check("R8 no-op keeps W", outs[3], 8'h3C);
    check("R13 print repeat", outs[3], outs[2]);
    check("R2 stamp first print", stamps[0], 17);
    check("R2 stamp last print", stamps[3], 41);
    check("R2 strobe single clock", dblStb, 0);

    // R1: registers zero after reset even after prior nonzero contents
    prog[0] = enc(PRT, 3'd0, 8'h00);
    prog[1] = enc(RDW, 3'd0, 8'h00);
    prog[2] = enc(PRT, 3'd0, 8'h00);
    prog[3] = enc(RDW, 3'd1, 8'h00);
    prog[4] = enc(PRT, 3'd0, 8'h00);
    prog[5] = enc(RDW, 3'd2, 8'h00);
    prog[6] = enc(PRT, 3'd0, 8'h00);
    prog[7] = enc(RDW, 3'd3, 8'h00);
    prog[8] = enc(PRT, 3'd0, 8'h00);
    prog[9] = enc(JMP, 3'd0, 8'd9);
    runProg(10, 40, 1'b0, '0);
    check("R1 print count", nOut, 5);
    for (int i = 0; i < 5; i++) begin
      check("R1 cleared value", outs[i], 8'h00);
      check("R2 cadence stamp", stamps[i], 6 * i + 2);
    end

    // R5: ALU slots written and read directly
    prog[0]  = enc(LIT, 3'd6, 8'h77);
    prog[1]  = enc(LIT, 3'd7, 8'h12);
    prog[2]  = enc(RDW, 3'd6, 8'h00);
    prog[3]  = enc(PRT, 3'd0, 8'h00);
    prog[4]  = enc(RDW, 3'd7, 8'h00);
    prog[5]  = enc(PRT, 3'd0, 8'h00);
    prog[6]  = enc(LIT, 3'd4, 8'h0F);
    prog[7]  = enc(RDW, 3'd4, 8'h00);
    prog[8]  = enc(WRR, 3'd5, 8'h00);
    prog[9]  = enc(RDW, 3'd5, 8'h00);
    prog[10] = enc(PRT, 3'd0, 8'h00);
    prog[11] = enc(JMP, 3'd0, 8'd11);
    runProg(12, 45, 1'b0, '0);
    check("R5 print count", nOut, 3);
    check("R5 result slot writable", outs[0], 8'h77);
    check("R5 flag slot writable", outs[1], 8'h12);
    check("R5 operand B via W", outs[2], 8'h0F);

    // R6 R7 R5: exhaustive control sweep over several operand pairs
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 256; c++) begin
        logic [7:0] a, b, r, f;
        case (p)
          0: begin a = 8'h00; b = 8'h00; end
          1: begin a = 8'h13; b = 8'h2C; end
          2: begin a = 8'hFF; b = 8'h01; end
          default: begin a = 8'h80; b = 8'h7F; end
        endcase
        r = aluRef(a, b, 8'(c & 8'h3F));
        f = {6'd0, r[7], (r == 8'h00)};
        prog[0]  = enc(LIT, 3'd4, a);
        prog[1]  = enc(LIT, 3'd5, b);
        prog[2]  = enc(ALU, 3'd0, 8'(c));
        prog[3]  = enc(RDW, 3'd6, 8'h00);
        prog[4]  = enc(PRT, 3'd0, 8'h00);
        prog[5]  = enc(RDW, 3'd7, 8'h00);
        prog[6]  = enc(PRT, 3'd0, 8'h00);
        prog[7]  = enc(RDW, 3'd4, 8'h00);
        prog[8]  = enc(PRT, 3'd0, 8'h00);
        prog[9]  = enc(RDW, 3'd5, 8'h00);
        prog[10] = enc(PRT, 3'd0, 8'h00);
        prog[11] = enc(JMP, 3'd0, 8'd11);
        runProg(12, 36, 1'b0, '0);
        check("R6 ALU result", outs[0], r);
        check("R7 ALU flags", outs[1], f);
        check("R5 operand A kept", outs[2], a);
        check("R5 operand B kept", outs[3], b);
      end
    end

    // R9 R10: jumps with truncated target, taken and untaken zero test
    for (int a = 0; a < 64; a++) prog[a] = enc(NOP, 3'd0, 8'h00);
    prog[0]  = enc(JMP, 3'd0, 8'hC5);
    prog[1]  = enc(LIT, 3'd0, 8'hEE);
    prog[2]  = enc(RDW, 3'd0, 8'h00);
    prog[3]  = enc(PRT, 3'd0, 8'h00);
    prog[4]  = enc(JMP, 3'd0, 8'd4);
    prog[5]  = enc(LIT, 3'd1, 8'h07);
    prog[6]  = enc(JZ,  3'd0, 8'd10);
    prog[7]  = enc(LIT, 3'd1, 8'h99);
    prog[8]  = enc(RDW, 3'd1, 8'h00);
    prog[9]  = enc(PRT, 3'd0, 8'h00);
    prog[10] = enc(RDW, 3'd1, 8'h00);
    prog[11] = enc(PRT, 3'd0, 8'h00);
    prog[12] = enc(JZ,  3'd0, 8'd3);
    prog[13] = enc(LIT, 3'd2, 8'h42);
    prog[14] = enc(RDW, 3'd2, 8'h00);
    prog[15] = enc(PRT, 3'd0, 8'h00);
    prog[16] = enc(JMP, 3'd0, 8'd16);
    runProg(17, 40, 1'b0, '0);
    check("R9 R10 print count", nOut, 2);
    check("R10 taken zero jump", outs[0], 8'h07);
    check("R10 untaken falls through", outs[1], 8'h42);
    check("R9 truncated target timing", stamps[0], 14);
    check("R10 fallthrough timing", stamps[1], 26);

    // R11: counter wraps from 63 to 0
    for (int a = 0; a < 64; a++) prog[a] = enc(NOP, 3'd0, 8'h00);
    prog[0]  = enc(RDW, 3'd0, 8'h00);
    prog[1]  = enc(JZ,  3'd0, 8'd62);
    prog[2]  = enc(PRT, 3'd0, 8'h00);
    prog[3]  = enc(JMP, 3'd0, 8'd3);
    prog[62] = enc(LIT, 3'd0, 8'h5A);
    prog[63] = enc(NOP, 3'd0, 8'h00);
    runProg(64, 40, 1'b0, '0);
    check("R11 wrap print count", nOut, 1);
    check("R11 wrap value", outs[0], 8'h5A);
    check("R11 wrap timing", stamps[0], 20);

    // R12: write to address 0 in the clock of its first fetch
    prog[0] = enc(LIT, 3'd0, 8'h05);
    prog[1] = enc(RDW, 3'd0, 8'h00);
    prog[2] = enc(PRT, 3'd0, 8'h00);
    prog[3] = enc(JMP, 3'd0, 8'd0);
    runProg(4, 30, 1'b1, enc(LIT, 3'd0, 8'h09));
    check("R12 race print count", nOut, 2);
    check("R12 old word on colliding fetch", outs[0], 8'h05);
    check("R12 new word on later fetch", outs[1], 8'h09);
    check("R12 first pass timing", stamps[0], 8);
    check("R12 second pass timing", stamps[1], 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule